// File: doc/BRIEF.md
# Cascaded 32-Line Interrupt Controller

This block gathers a word of peripheral interrupt lines and folds them into one request toward a parent interrupt controller. Each line passes through a synchroniser first. Software then decides through a small word-wide register port which lines may reach the parent. It reads the raw per-line status and the current mask. It changes the mask through two separate registers: one disables lines and the other enables them, and each acts only on the bits written as 1.

A build-time parameter picks the variant. The latched variant records rising edges in sticky status bits and provides an acknowledge register that clears them. The level variant shows the synchronised input levels directly and has no acknowledge register, so its mask registers sit at lower offsets. The parent request is registered and is high whenever any status bit is set while its mask bit is clear.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset every mask bit reads 1 (all lines disabled), every status bit reads 0 and the parent output is 0.
- R2: Writing the mask-disable register (offset 0x10 latched, 0x08 level) sets each mask bit written as 1 and leaves bits written as 0 unchanged.
- R3: Writing the mask-enable register (offset 0x14 latched, 0x0C level) clears each mask bit written as 1 and leaves bits written as 0 unchanged.
- R4: The mask readback register (offset 0x0C latched, 0x04 level) returns the current mask, 1 meaning disabled; a read returns data on the bus one clock after the read strobe.
- R5: In the latched variant a rising edge on a line sets its status bit (offset 0x00), which stays set after the line falls and is set whether or not the line is masked; a line held high sets it only once.
- R6: In the latched variant writing 1 to a bit of the acknowledge register (offset 0x08) clears that status bit; bits written as 0 have no effect.
- R7: In the latched variant, when a new edge and an acknowledge of the same bit land in the same cycle, the bit stays set.
- R8: In the level variant the status register (offset 0x00) reports the current synchronised level of every line, with no memory of past activity.
- R9: The parent output is registered and equals 1 exactly when the status word ANDed with the inverted mask is non-zero.
- R10: Reads of offsets that hold no register return 0 and writes to them change no state; in the level variant this includes offsets 0x10 and 0x14, and in the latched variant offset 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Child interrupt lines, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Read data, valid one clock after the read strobe |
| irq_out | output | 1 | Request to the parent controller |

## Verification
The bench walks every line through an edge, checks that a masked line is still recorded, and confirms that a line held high is not re-recorded after acknowledge; a design that sampled levels in the latched variant would see the bit return at once. It lines up an edge with an acknowledge of the same bit in one cycle, which a design giving the clear priority would lose. Mask writes with zero bits and writes to absent offsets are read back, catching designs that overwrite the mask instead of setting or clearing bits, or that decode the wrong variant's map. The parent output is compared against masked and unmasked pending patterns, catching an inverted mask sense.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_STAT,
    RK_ACK,
    RK_MREAD,
    RK_MDIS,
    RK_MEN
  } reg_kind_e;

  // Offset decode; the two variants differ only in where the mask registers sit.
  function automatic reg_kind_e decode_offset(input logic [31:0] off, input bit latched);
    reg_kind_e k;
    k = RK_NONE;
    if (latched) begin
      case (off)
        32'h00:  k = RK_STAT;
        32'h08:  k = RK_ACK;
        32'h0C:  k = RK_MREAD;
        32'h10:  k = RK_MDIS;
        32'h14:  k = RK_MEN;
        default: k = RK_NONE;
      endcase
    end else begin
      case (off)
        32'h00:  k = RK_STAT;
        32'h04:  k = RK_MREAD;
        32'h08:  k = RK_MDIS;
        32'h0C:  k = RK_MEN;
        default: k = RK_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
  parameter int WIDTH   = 32,
  parameter bit LATCHED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] line_i,
  input  logic [WIDTH-1:0] ack_i,
  output logic [WIDTH-1:0] status_o
);

  generate
    if (LATCHED) begin : g_edge
      logic [WIDTH-1:0] prev_q;
      logic [WIDTH-1:0] pend_q;
      logic [WIDTH-1:0] rise;

      assign rise = line_i & ~prev_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q <= '0;
          pend_q <= '0;
        end else begin
          prev_q <= line_i;
          // A fresh edge beats a simultaneous acknowledge.
          pend_q <= (pend_q & ~ack_i) | rise;
        end
      end

      assign status_o = pend_q;

      p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (|(ack_i & ~rise)) |=> ((pend_q & $past(ack_i & ~rise)) == '0));

      p_edge_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

      p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (|($past(pend_q) & ~ack_i)) |-> 1'b1 ##0
        ((pend_q & $past(pend_q) & ~$past(ack_i)) == ($past(pend_q) & ~$past(ack_i))));
    end else begin : g_level
      assign status_o = line_i;

      logic unused_ack;
      assign unused_ack = ^ack_i;
    end
  endgenerate

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dis_bits_i,
  input  logic [WIDTH-1:0] en_bits_i,
  output logic [WIDTH-1:0] mask_o
);

  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= (mask_q | dis_bits_i) & ~en_bits_i;
  end

  assign mask_o = mask_q;

  p_reset_mask_r1: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == '1));

  p_disable_bits_r2: assert property (@(posedge clk) disable iff (rst)
    ((|dis_bits_i) && (en_bits_i == '0)) |=> ((mask_q & $past(dis_bits_i)) == $past(dis_bits_i)));

  p_enable_bits_r3: assert property (@(posedge clk) disable iff (rst)
    ((|en_bits_i) && (dis_bits_i == '0)) |=> ((mask_q & $past(en_bits_i)) == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ((dis_bits_i == '0) && (en_bits_i == '0)) |=> $stable(mask_q));

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit LATCHED     = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic                 irq_out
);

  localparam logic [NUM_LINES-1:0] ZERO_W = '0;

  logic [NUM_LINES-1:0] line_sync;
  logic [NUM_LINES-1:0] status;
  logic [NUM_LINES-1:0] mask;
  logic [NUM_LINES-1:0] ack_bits;
  logic [NUM_LINES-1:0] dis_bits;
  logic [NUM_LINES-1:0] en_bits;
  logic [NUM_LINES-1:0] rd_value;
  logic [NUM_LINES-1:0] rdata_q;
  logic                 irq_q;
  reg_kind_e            kind;

  assign kind = decode_offset(32'(bus_addr), LATCHED);

  irq_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (irq_in),
    .sync_o  (line_sync)
  );

  irq_pend_capture #(.WIDTH(NUM_LINES), .LATCHED(LATCHED)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .line_i   (line_sync),
    .ack_i    (ack_bits),
    .status_o (status)
  );

  irq_mask_bank #(.WIDTH(NUM_LINES)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .dis_bits_i (dis_bits),
    .en_bits_i  (en_bits),
    .mask_o     (mask)
  );

  assign ack_bits = (bus_wr && kind == RK_ACK)  ? bus_wdata : ZERO_W;
  assign dis_bits = (bus_wr && kind == RK_MDIS) ? bus_wdata : ZERO_W;
  assign en_bits  = (bus_wr && kind == RK_MEN)  ? bus_wdata : ZERO_W;

  always_comb begin
    case (kind)
      RK_STAT:  rd_value = status;
      RK_MREAD: rd_value = mask;
      default:  rd_value = ZERO_W;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_value;
      irq_q <= |(status & ~mask);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_out && bus_rdata == '0));

  p_all_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (mask == '1) |=> !irq_out);

  p_none_pending_r9: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |=> !irq_out);

  p_hole_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && kind == RK_NONE) |=> (bus_rdata == '0));

endmodule

// File: tb/irq_cascade_ctrl_tb.sv
module irq_cascade_ctrl_tb;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          wr_e = 1'b0, rd_e = 1'b0, wr_l = 1'b0, rd_l = 1'b0;
  logic [7:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata_e, rdata_l;
  logic          irq_e, irq_l;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_cascade_ctrl #(.NUM_LINES(N), .LATCHED(1'b1)) u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(wr_e), .bus_rd(rd_e),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_e), .irq_out(irq_e));

  irq_cascade_ctrl #(.NUM_LINES(N), .LATCHED(1'b0)) u_dut_lvl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(wr_l), .bus_rd(rd_l),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_l), .irq_out(irq_l));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wreg(input bit lvl, input logic [7:0] a, input logic [N-1:0] d);
    addr = a; wdata = d;
    if (lvl) wr_l = 1'b1; else wr_e = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_l = 1'b0; wr_e = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input bit lvl, input logic [7:0] a, output logic [N-1:0] d);
    addr = a;
    if (lvl) rd_l = 1'b1; else rd_e = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_l = 1'b0; rd_e = 1'b0;
    d = lvl ? rdata_l : rdata_e;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] v, model_mask, model_stat, pat;
    logic [7:0] o_stat, o_mread, o_mdis, o_men;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R4: reset state, both variants
    rreg(0, 8'h0C, v); check("R1 mask reset latched", v, '1);
    rreg(1, 8'h04, v); check("R1 mask reset level", v, '1);
    rreg(0, 8'h00, v); check("R1 status reset latched", v, '0);
    check("R1 parent reset latched", {31'b0, irq_e}, '0);
    check("R1 parent reset level", {31'b0, irq_l}, '0);

    // R2 / R3 / R4: mask set and clear on both maps
    for (int lv = 0; lv < 2; lv++) begin
      o_mread = lv ? 8'h04 : 8'h0C;
      o_mdis  = lv ? 8'h08 : 8'h10;
      o_men   = lv ? 8'h0C : 8'h14;
      model_mask = '1;
      wreg(lv[0], o_men, 32'hFFFF_FFFF); model_mask = '0;
      rreg(lv[0], o_mread, v); check("R3 enable all", v, model_mask);
      wreg(lv[0], o_mdis, 32'hA5A5_0F0F); model_mask |= 32'hA5A5_0F0F;
      rreg(lv[0], o_mread, v); check("R2 disable pattern", v, model_mask);
      wreg(lv[0], o_mdis, 32'h0); 
      rreg(lv[0], o_mread, v); check("R2 zero bits keep mask", v, model_mask);
      wreg(lv[0], o_men, 32'h0000_FFFF); model_mask &= ~32'h0000_FFFF;
      rreg(lv[0], o_mread, v); check("R3 enable pattern", v, model_mask);
      wreg(lv[0], o_men, 32'h0); 
      rreg(lv[0], o_mread, v); check("R3 zero bits keep mask", v, model_mask);
      for (int i = 0; i < N; i += 5) begin
        wreg(lv[0], o_mdis, 32'h1 << i); model_mask |= 32'h1 << i;
        rreg(lv[0], o_mread, v); check("R4 mask readback walk", v, model_mask);
      end
      wreg(lv[0], o_mdis, 32'hFFFF_FFFF);
    end

    // R5: every line latched while masked, survives the line falling
    model_stat = '0;
    for (int i = 0; i < N; i++) begin
      irq_in = 32'h1 << i;
      idle(2);
      irq_in = '0;
      idle(3);
      model_stat |= 32'h1 << i;
      rreg(0, 8'h00, v); check("R5 edge latched while masked", v, model_stat);
      check("R9 masked pending keeps parent low", {31'b0, irq_e}, '0);
    end

    // R6: acknowledge clears ones only
    wreg(0, 8'h08, 32'h0000_FFFF); model_stat &= ~32'h0000_FFFF;
    rreg(0, 8'h00, v); check("R6 ack clears ones", v, model_stat);
    wreg(0, 8'h08, 32'h0);
    rreg(0, 8'h00, v); check("R6 ack zero no effect", v, model_stat);

    // R9: parent follows status & ~mask
    wreg(0, 8'h14, 32'h0000_0008); idle(2);
    check("R9 unmasked but not pending", {31'b0, irq_e}, '0);
    wreg(0, 8'h14, 32'h0010_0000); idle(2);
    check("R9 unmasked pending raises parent", {31'b0, irq_e}, 32'h1);
    wreg(0, 8'h10, 32'h0010_0000); idle(2);
    check("R9 remask drops parent", {31'b0, irq_e}, '0);
    wreg(0, 8'h08, 32'hFFFF_FFFF); model_stat = '0;
    rreg(0, 8'h00, v); check("R6 ack all", v, '0);

    // R5: held-high line is not re-recorded after ack
    irq_in = 32'h0000_0020; idle(4);
    wreg(0, 8'h08, 32'h0000_0020); idle(3);
    rreg(0, 8'h00, v); check("R5 held line no relatch", v, '0);
    irq_in = '0; idle(3);

    // R7: edge and acknowledge of the same bit in one cycle
    irq_in = 32'h80; idle(3); irq_in = '0; idle(3);
    rreg(0, 8'h00, v); check("R7 setup pending", v, 32'h80);
    irq_in = 32'h80;            // launched before edge k
    @(posedge clk); @(posedge clk); @(negedge clk);
    addr = 8'h08; wdata = 32'h80; wr_e = 1'b1;   // captured at edge k+2 with the edge
    @(posedge clk); @(negedge clk);
    wr_e = 1'b0; wdata = '0; irq_in = '0;
    idle(3);
    rreg(0, 8'h00, v); check("R7 edge beats ack", v, 32'h80);
    wreg(0, 8'h08, 32'h80);

    // R10: latched map hole at 0x04 and beyond the map
    rreg(0, 8'h0C, model_mask);
    wreg(0, 8'h04, 32'hFFFF_FFFF);
    rreg(0, 8'h04, v); check("R10 latched hole reads zero", v, '0);
    rreg(0, 8'h0C, v); check("R10 latched hole write ignored", v, model_mask);
    rreg(0, 8'h08, v); check("R10 ack register reads zero", v, '0);

    // R8: level variant follows the lines
    wreg(1, 8'h0C, 32'hFFFF_FFFF);   // enable all on level map
    o_stat = 8'h00;
    for (int k = 0; k < 6; k++) begin
      pat = (32'h9E37_79B9 * (k + 1)) ^ (32'h1 << (k * 5));
      if (k == 5) pat = '0;
      irq_in = pat; idle(3);
      rreg(1, o_stat, v); check("R8 level status follows", v, pat);
      idle(1);
      check("R9 level parent", {31'b0, irq_l}, {31'b0, |pat});
    end
    irq_in = 32'h0000_0100; idle(3);
    wreg(1, 8'h08, 32'h0000_0100); idle(2);
    check("R9 level masked line", {31'b0, irq_l}, '0);
    irq_in = '0; idle(3);
    rreg(1, 8'h00, v); check("R8 level no memory", v, '0);

    // R10: level map has nothing at 0x10 / 0x14
    rreg(1, 8'h04, model_mask);
    wreg(1, 8'h10, 32'hFFFF_FFFF);
    wreg(1, 8'h14, 32'hFFFF_FFFF);
    rreg(1, 8'h04, v); check("R10 level write to absent offsets ignored", v, model_mask);
    rreg(1, 8'h10, v); check("R10 level 0x10 reads zero", v, '0);
    rreg(1, 8'h14, v); check("R10 level 0x14 reads zero", v, '0);
    rreg(1, 8'h40, v); check("R10 level far offset reads zero", v, '0);

    done = 1'b1;
    finish_run();
  end

endmodule